// File: doc/BRIEF.md
# Clock Source Control Register

This block is the control and status word of a clock controller. Software sets or clears the enables of an external crystal oscillator, its bypass option, a clock-failure detector, a main PLL and a second PLL. Hardware reports the oscillator-ready flag and the two PLL lock flags in the same word. Every software write passes through an interlock filter first. That filter refuses to switch off any source that currently feeds the system clock, and it freezes the bypass option while the oscillator is enabled.

Hardware can also override software. Entry into a low-power state forces the oscillator and PLL enables to zero. The oscillator-ready flag stays high for a fixed number of oscillator clock periods after the oscillator is disabled, and those periods are counted as strobes in the register clock domain. The failure detector runs only while it is enabled and the oscillator is ready. It shuts itself off on a failure event and raises a sticky interrupt that is cleared by a pulse.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset every bit of `rd_data_o` reads 0, and `det_active_o` and `fail_irq_o` are 0. Bits 23:20 and every bit not named in R2 or R9 always read 0.
- R2: A write (`wr_en_i`=1) takes effect at the next clock edge. The field positions are: oscillator enable at bit 16, bypass at bit 18, detector enable at bit 19, main PLL enable at bit 24 and second PLL enable at bit 26. Any of these may be set, and any may be cleared unless R3 to R7 prevent it.
- R3: While `lowpwr_i`=1, the next edge clears bits 16, 24 and 26, even against a simultaneous write of 1 and even against the interlocks. Bits 18 and 19 still take the write.
- R4: A write of 0 to bit 16 is ignored while `sysclk_sel_i`=1 (oscillator), or while `sysclk_sel_i`=2 (main PLL) with `pll_src_i`=0 (main PLL fed by the oscillator).
- R5: A write of 0 to bit 24 is ignored while `sysclk_sel_i`=2 or `sysclk_pend_i`=1.
- R6: A write of 0 to bit 26 is ignored while `sysclk_sel_i`=2 and `pll_src_i`=1 (main PLL fed by the second PLL).
- R7: Bit 18 changes on a write only if bit 16 reads 0 before that write. Otherwise it keeps its value.
- R8: Bit 17 (oscillator ready) takes the value of `osc_stable_i` one edge after it is sampled, while bit 16 is 1. Once bit 16 is 0, bit 17 holds its value and falls at the edge that samples the 6th `osc_tick_i` pulse.
- R9: Bits 25 and 27 show `pll_lock_i` and `pll2_lock_i` one edge later. Writes to bits 17, 25 and 27 have no effect.
- R10: `det_active_o` is 1 only when bit 19 is 1, bit 17 is 1, and no failure has been seen since the oscillator was last ready. It drops at the edge after `osc_fail_i` is seen while active.
- R11: `fail_irq_o` is set at the edge after `osc_fail_i` is seen while `det_active_o`=1. It holds until an edge with `fail_clr_i`=1, and setting wins over clearing. A failure input while the detector is inactive does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register contents |
| lowpwr_i | input | 1 | Low-power state entry |
| sysclk_sel_i | input | 2 | Current system clock: 0 internal, 1 oscillator, 2 main PLL |
| sysclk_pend_i | input | 1 | Main PLL selected to become the system clock |
| pll_src_i | input | 1 | Main PLL input: 1 second PLL, 0 oscillator |
| osc_stable_i | input | 1 | Oscillator stable indication |
| osc_tick_i | input | 1 | One strobe per oscillator clock period |
| pll_lock_i | input | 1 | Main PLL lock status |
| pll2_lock_i | input | 1 | Second PLL lock status |
| osc_fail_i | input | 1 | Oscillator failure event |
| fail_clr_i | input | 1 | Clears the failure interrupt |
| det_active_o | output | 1 | Failure detector running |
| fail_irq_o | output | 1 | Sticky failure interrupt |

## Verification
The collision that matters is a low-power entry and a software write arriving in the same cycle. The vector table drives `lowpwr_i` both alone, against a selection that would otherwise lock the oscillator and PLLs on, and together with a write of all ones. After each edge the bench reads the whole word. It expects the hardware clear to win on bits 16, 24 and 26, while bits 18 and 19 follow the write under the normal bypass rule.

// File: rtl/clk_ctrl_pkg.sv
`timescale 1ns/1ps
package clk_ctrl_pkg;
  localparam int OSC_EN_B   = 16;
  localparam int OSC_RDY_B  = 17;
  localparam int BYP_B      = 18;
  localparam int DET_EN_B   = 19;
  localparam int PLL_EN_B   = 24;
  localparam int PLL_RDY_B  = 25;
  localparam int PLL2_EN_B  = 26;
  localparam int PLL2_RDY_B = 27;

  typedef enum logic [1:0] {
    SYS_INT = 2'd0,
    SYS_OSC = 2'd1,
    SYS_PLL = 2'd2
  } sys_sel_e;

  typedef struct packed {
    logic pll2_en;
    logic pll_en;
    logic det_en;
    logic byp;
    logic osc_en;
  } ctl_t;
endpackage

// File: rtl/clk_ctrl_wr_filter.sv
`timescale 1ns/1ps
module clk_ctrl_wr_filter
  import clk_ctrl_pkg::*;
(
  input  ctl_t       cur_i,
  input  logic       we_i,
  input  ctl_t       wd_i,
  input  logic [1:0] sel_i,
  input  logic       pend_i,
  input  logic       pll_src_i,
  input  logic       lowpwr_i,
  output ctl_t       nxt_o
);
  logic osc_busy, pll_busy, pll2_busy;

  assign osc_busy  = (sel_i == SYS_OSC) || ((sel_i == SYS_PLL) && !pll_src_i);
  assign pll_busy  = (sel_i == SYS_PLL) || pend_i;
  assign pll2_busy = (sel_i == SYS_PLL) && pll_src_i;

  always_comb begin
    nxt_o = cur_i;
    if (we_i) begin
      nxt_o.det_en  = wd_i.det_en;
      nxt_o.osc_en  = wd_i.osc_en  | (cur_i.osc_en  & osc_busy);
      nxt_o.pll_en  = wd_i.pll_en  | (cur_i.pll_en  & pll_busy);
      nxt_o.pll2_en = wd_i.pll2_en | (cur_i.pll2_en & pll2_busy);
      // bypass frozen while the oscillator is enabled
      if (!cur_i.osc_en) nxt_o.byp = wd_i.byp;
    end
    if (lowpwr_i) begin
      nxt_o.osc_en  = 1'b0;
      nxt_o.pll_en  = 1'b0;
      nxt_o.pll2_en = 1'b0;
    end
  end
endmodule

// File: rtl/clk_ctrl_rdy_track.sv
`timescale 1ns/1ps
module clk_ctrl_rdy_track #(
  parameter int DROP_TICKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stable_i,
  input  logic tick_i,
  output logic rdy_o
);
  localparam int CNT_W = $clog2(DROP_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DROP_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      rdy_o <= stable_i;
      cnt_q <= '0;
    end else if (rdy_o && tick_i) begin
      if (cnt_q == LAST) begin
        rdy_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ctrl_fail_det.sv
`timescale 1ns/1ps
module clk_ctrl_fail_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_en_i,
  input  logic rdy_i,
  input  logic fail_i,
  input  logic clr_i,
  output logic active_o,
  output logic irq_o
);
  logic trip_q;

  assign active_o = det_en_i & rdy_i & ~trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      // re-arm once the oscillator or the enable goes away
      if (!rdy_i || !det_en_i) trip_q <= 1'b0;
      else if (active_o && fail_i) trip_q <= 1'b1;
      if (active_o && fail_i) irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_ctrl_reg.sv
`timescale 1ns/1ps
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DROP_TICKS = 6,
  parameter int N_PLL      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lowpwr_i,
  input  logic [1:0]        sysclk_sel_i,
  input  logic              sysclk_pend_i,
  input  logic              pll_src_i,
  input  logic              osc_stable_i,
  input  logic              osc_tick_i,
  input  logic              pll_lock_i,
  input  logic              pll2_lock_i,
  input  logic              osc_fail_i,
  input  logic              fail_clr_i,
  output logic              det_active_o,
  output logic              fail_irq_o
);
  ctl_t ctl_q, ctl_d, wd;
  logic osc_rdy;
  logic [N_PLL-1:0] lock_in, lock_q;

  assign wd.osc_en  = wr_data_i[OSC_EN_B];
  assign wd.byp     = wr_data_i[BYP_B];
  assign wd.det_en  = wr_data_i[DET_EN_B];
  assign wd.pll_en  = wr_data_i[PLL_EN_B];
  assign wd.pll2_en = wr_data_i[PLL2_EN_B];

  clk_ctrl_wr_filter u_filter (
    .cur_i     (ctl_q),
    .we_i      (wr_en_i),
    .wd_i      (wd),
    .sel_i     (sysclk_sel_i),
    .pend_i    (sysclk_pend_i),
    .pll_src_i (pll_src_i),
    .lowpwr_i  (lowpwr_i),
    .nxt_o     (ctl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  clk_ctrl_rdy_track #(.DROP_TICKS(DROP_TICKS)) u_rdy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctl_q.osc_en),
    .stable_i (osc_stable_i),
    .tick_i   (osc_tick_i),
    .rdy_o    (osc_rdy)
  );

  assign lock_in = {pll2_lock_i, pll_lock_i};

  for (genvar g = 0; g < N_PLL; g++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lock_q[g] <= 1'b0;
      else         lock_q[g] <= lock_in[g];
    end
  end

  clk_ctrl_fail_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .det_en_i (ctl_q.det_en),
    .rdy_i    (osc_rdy),
    .fail_i   (osc_fail_i),
    .clr_i    (fail_clr_i),
    .active_o (det_active_o),
    .irq_o    (fail_irq_o)
  );

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[OSC_EN_B]   = ctl_q.osc_en;
    rd_data_o[OSC_RDY_B]  = osc_rdy;
    rd_data_o[BYP_B]      = ctl_q.byp;
    rd_data_o[DET_EN_B]   = ctl_q.det_en;
    rd_data_o[PLL_EN_B]   = ctl_q.pll_en;
    rd_data_o[PLL_RDY_B]  = lock_q[0];
    rd_data_o[PLL2_EN_B]  = ctl_q.pll2_en;
    rd_data_o[PLL2_RDY_B] = lock_q[N_PLL-1];
  end
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
`timescale 1ns/1ps
module clk_ctrl_reg_chk
  import clk_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              lowpwr_i,
  input logic [1:0]        sysclk_sel_i,
  input logic              pll_src_i,
  input logic              sysclk_pend_i,
  input logic              osc_tick_i,
  input logic              pll_lock_i,
  input logic              pll2_lock_i,
  input logic              osc_fail_i,
  input logic              fail_clr_i,
  input logic              det_active_o,
  input logic              fail_irq_o
);
  logic osc_drv, pll_drv, pll2_drv;
  assign osc_drv  = (sysclk_sel_i == SYS_OSC) || ((sysclk_sel_i == SYS_PLL) && !pll_src_i);
  assign pll_drv  = (sysclk_sel_i == SYS_PLL) || sysclk_pend_i;
  assign pll2_drv = (sysclk_sel_i == SYS_PLL) && pll_src_i;

  p_lp_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i |=> !rd_data_o[OSC_EN_B] && !rd_data_o[PLL_EN_B] && !rd_data_o[PLL2_EN_B]);

  p_osc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[OSC_EN_B] && osc_drv && !lowpwr_i) |=> rd_data_o[OSC_EN_B]);

  p_pll_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[PLL_EN_B] && pll_drv && !lowpwr_i) |=> rd_data_o[PLL_EN_B]);

  p_pll2_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[PLL2_EN_B] && pll2_drv && !lowpwr_i) |=> rd_data_o[PLL2_EN_B]);

  p_byp_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[OSC_EN_B] |=> $stable(rd_data_o[BYP_B]));

  p_rdy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[OSC_EN_B] && !osc_tick_i) |=> $stable(rd_data_o[OSC_RDY_B]));

  p_lock_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_lock_i |=> rd_data_o[PLL_RDY_B]);

  p_lock2_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll2_lock_i |=> !rd_data_o[PLL2_RDY_B]);

  p_det_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_active_o |-> (rd_data_o[DET_EN_B] && rd_data_o[OSC_RDY_B]));

  p_irq_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_active_o && osc_fail_i) |=> fail_irq_o);

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_irq_o && !fail_clr_i) |=> fail_irq_o);
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_data_o     (rd_data_o),
  .lowpwr_i      (lowpwr_i),
  .sysclk_sel_i  (sysclk_sel_i),
  .pll_src_i     (pll_src_i),
  .sysclk_pend_i (sysclk_pend_i),
  .osc_tick_i    (osc_tick_i),
  .pll_lock_i    (pll_lock_i),
  .pll2_lock_i   (pll2_lock_i),
  .osc_fail_i    (osc_fail_i),
  .fail_clr_i    (fail_clr_i),
  .det_active_o  (det_active_o),
  .fail_irq_o    (fail_irq_o)
);

// File: tb/clk_ctrl_reg_tb.sv
`timescale 1ns/1ps
module clk_ctrl_reg_tb;
  localparam int DW = 32;
  localparam int NV = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          lowpwr_i = 1'b0;
  logic [1:0]    sysclk_sel_i = 2'd0;
  logic          sysclk_pend_i = 1'b0;
  logic          pll_src_i = 1'b0;
  logic          osc_stable_i = 1'b0;
  logic          osc_tick_i = 1'b0;
  logic          pll_lock_i = 1'b0;
  logic          pll2_lock_i = 1'b0;
  logic          osc_fail_i = 1'b0;
  logic          fail_clr_i = 1'b0;
  logic          det_active_o;
  logic          fail_irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  clk_ctrl_reg u_dut (.*);

  always #10 clk_i = ~clk_i;

  // {we, wd[4:0], sel, pend, src, lp, exp[4:0]}; 5-bit field order {pll2, pll, det, byp, osc}
  localparam logic [15:0] VECS [NV] = '{
    {1'b1, 5'b00110, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00110},
    {1'b1, 5'b11111, 2'd0, 1'b0, 1'b0, 1'b0, 5'b11111},
    {1'b1, 5'b11101, 2'd0, 1'b0, 1'b0, 1'b0, 5'b11111},
    {1'b1, 5'b00010, 2'd1, 1'b0, 1'b0, 1'b0, 5'b00011},
    {1'b1, 5'b11011, 2'd1, 1'b0, 1'b0, 1'b0, 5'b11011},
    {1'b1, 5'b00000, 2'd2, 1'b0, 1'b1, 1'b0, 5'b11010},
    {1'b1, 5'b00000, 2'd2, 1'b0, 1'b0, 1'b0, 5'b01000},
    {1'b1, 5'b01001, 2'd2, 1'b0, 1'b0, 1'b0, 5'b01001},
    {1'b1, 5'b00000, 2'd0, 1'b1, 1'b0, 1'b0, 5'b01000},
    {1'b1, 5'b00000, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00000},
    {1'b1, 5'b11101, 2'd0, 1'b0, 1'b0, 1'b0, 5'b11101},
    {1'b0, 5'b00000, 2'd2, 1'b0, 1'b0, 1'b1, 5'b00100},
    {1'b1, 5'b11111, 2'd0, 1'b0, 1'b0, 1'b1, 5'b00110},
    {1'b0, 5'b00000, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00110}
  };

  string vtag [NV];

  function automatic logic [DW-1:0] mk(input logic [4:0] f);
    logic [DW-1:0] w = '0;
    w[16] = f[0]; w[18] = f[1]; w[19] = f[2]; w[24] = f[3]; w[26] = f[4];
    return w;
  endfunction

  function automatic logic [4:0] ens(input logic [DW-1:0] w);
    return {w[26], w[24], w[19], w[18], w[16]};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    vtag[0] = "R2";  vtag[1] = "R2";  vtag[2] = "R7";  vtag[3] = "R4";
    vtag[4] = "R7";  vtag[5] = "R6";  vtag[6] = "R4";  vtag[7] = "R2";
    vtag[8] = "R5";  vtag[9] = "R5";  vtag[10] = "R2"; vtag[11] = "R3";
    vtag[12] = "R3"; vtag[13] = "R2";

    repeat (2) @(negedge clk_i);
    chk("R1 reset word", rd_data_o, '0);
    chk("R1 reset irq/active", {30'd0, fail_irq_o, det_active_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      wr_en_i       = VECS[i][15];
      wr_data_i     = mk(VECS[i][14:10]);
      sysclk_sel_i  = VECS[i][9:8];
      sysclk_pend_i = VECS[i][7];
      pll_src_i     = VECS[i][6];
      lowpwr_i      = VECS[i][5];
      cyc();
      chk(vtag[i], DW'(ens(rd_data_o)), DW'(VECS[i][4:0]));
    end
    wr_en_i = 1'b0; lowpwr_i = 1'b0; sysclk_sel_i = 2'd0;
    sysclk_pend_i = 1'b0; pll_src_i = 1'b0;

    // R1 R9: reserved and flag bits ignore writes
    wr_en_i = 1'b1; wr_data_i = mk(5'b00110) | 32'h0AF2_0000;
    cyc();
    wr_en_i = 1'b0;
    chk("R9 flags/reserved write", rd_data_o, mk(5'b00110));

    // R8: ready follows stable while enabled
    osc_stable_i = 1'b1;
    wr_en_i = 1'b1; wr_data_i = mk(5'b00111);
    cyc();
    wr_en_i = 1'b0;
    chk("R8 rdy not yet", DW'(rd_data_o[17]), 0);
    cyc();
    chk("R8 rdy set", DW'(rd_data_o[17]), 1);
    chk("R10 detector active", DW'(det_active_o), 1);

    // R10 R11: failure trips detector, sets irq
    osc_fail_i = 1'b1;
    cyc();
    osc_fail_i = 1'b0;
    chk("R11 irq set", DW'(fail_irq_o), 1);
    chk("R10 detector off after fail", DW'(det_active_o), 0);
    cyc();
    chk("R11 irq held", DW'(fail_irq_o), 1);
    fail_clr_i = 1'b1;
    cyc();
    fail_clr_i = 1'b0;
    chk("R11 irq cleared", DW'(fail_irq_o), 0);

    // R8: delayed drop after disable
    wr_en_i = 1'b1; wr_data_i = mk(5'b00110);
    cyc();
    wr_en_i = 1'b0; osc_stable_i = 1'b0;
    chk("R8 rdy held at disable", DW'(rd_data_o[17]), 1);
    for (int k = 0; k < 5; k++) begin
      osc_tick_i = 1'b1;
      cyc();
      osc_tick_i = 1'b0;
      cyc();
    end
    chk("R8 rdy after 5 ticks", DW'(rd_data_o[17]), 1);
    osc_tick_i = 1'b1;
    cyc();
    osc_tick_i = 1'b0;
    chk("R8 rdy after 6th tick", DW'(rd_data_o[17]), 0);

    // R10 R11: inactive detector ignores failure
    chk("R10 inactive without ready", DW'(det_active_o), 0);
    osc_fail_i = 1'b1;
    cyc();
    osc_fail_i = 1'b0;
    chk("R11 no irq when inactive", DW'(fail_irq_o), 0);

    // R9: lock flags
    pll_lock_i = 1'b1;
    cyc();
    chk("R9 pll lock", DW'({rd_data_o[27], rd_data_o[25]}), 1);
    pll_lock_i = 1'b0; pll2_lock_i = 1'b1;
    cyc();
    chk("R9 pll2 lock", DW'({rd_data_o[27], rd_data_o[25]}), 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule